// File: doc/BRIEF.md
# Tree-Structured Leading Zero Counter

This block takes a binary word and reports how many zero bits precede the first one when the word is read from its most significant end. Next to that count it raises a flag whenever every bit of the word is zero. It is intended for places such as floating-point normalisation, where a later stage needs the shift distance. That later stage must use the flag to qualify the count, because the count also has a defined value when the word holds no one at all.

The logic is purely combinational and is arranged as a balanced tree. The leaves are 2-bit cells, and each cell produces its own all-zero flag and a 1-bit partial count. Every level above the leaves joins two neighbouring half-width results into one result of twice the width. A join looks only at the two all-zero flags and the two partial counts, so no level ever searches the whole word. A single module definition, sized by its half-width, serves every level. The default operand width is 64 bits. Raising the width parameter to 128 adds exactly one more joining level.

Top module: `lead_zero_count`

## Requirements
- R1: With the default parameters, the operand is 64 bits wide, the count output is 6 bits wide and the flag output is 1 bit wide.
- R2: The flag output is 1 exactly when every operand bit is 0, and 0 otherwise.
- R3: When the operand is nonzero, the count equals the number of 0 bits above the highest bit that is set. Bit 63 is the most significant bit.
- R4: When the operand is all zero, the count reads all ones (63 with the default width).
- R5: When bit 63 of the operand is set, the count is 0, whatever the lower bits hold.
- R6: When only bit 0 is set, the count is 63 and the flag is 0. The count alone therefore does not tell this word apart from an all-zero word.
- R7: When the width parameter is set to 128, the count output becomes 7 bits wide. R2, R3 and R4 then hold over the 128-bit operand.
- R8: The outputs follow any change of the operand without a clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | WIDTH (64) | Operand; bit WIDTH-1 is the most significant bit |
| all_zero_o | output | 1 | High when the whole operand is zero |
| count_o | output | CNT_W (6) | Number of leading zero bits; all ones when the operand is zero |

## Verification
The checker takes for granted that every bit of the operand is a known 0 or 1. It skips evaluation while any bit is unknown, which is the situation before the bench first drives the word. After that first drive, the bench only ever assigns fully known two-state values. These come from the vector table, from single-bit and word-boundary patterns, and from random words that are right-shifted by a random distance so that every count value is reached. Each result is compared with a plain scan from the top bit downward.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

  // number of tree levels needed for a power-of-two width
  function automatic int lzc_levels(input int width);
    int lv;
    lv = 0;
    while ((1 << lv) < width) lv++;
    return lv;
  endfunction

  function automatic bit lzc_is_pow2(input int width);
    return (width >= 2) && ((width & (width - 1)) == 0);
  endfunction

endpackage

// File: rtl/lzc_cell2.sv
// Leaf cell: two operand bits to a flag and a 1-bit partial count.
module lzc_cell2 (
  input  logic [1:0] pair_i,
  output logic       zero_o,
  output logic       cnt_o
);

  always_comb begin
    zero_o = ~(pair_i[1] | pair_i[0]);
    cnt_o  = ~pair_i[1];
  end

endmodule

// File: rtl/lzc_merge.sv
// Joins two half-width results into one of twice the width.
module lzc_merge #(
  parameter int HALF_CW = 1,
  parameter int OUT_CW  = HALF_CW + 1
) (
  input  logic               hi_zero_i,
  input  logic               lo_zero_i,
  input  logic [HALF_CW-1:0] hi_cnt_i,
  input  logic [HALF_CW-1:0] lo_cnt_i,
  output logic               zero_o,
  output logic [OUT_CW-1:0]  cnt_o
);

  logic [HALF_CW-1:0] sel_hi;
  logic [HALF_CW-1:0] sel_lo;

  always_comb begin
    sel_lo = {HALF_CW{hi_zero_i}} & lo_cnt_i;
    sel_hi = {HALF_CW{~hi_zero_i}} & hi_cnt_i;
    zero_o = hi_zero_i & lo_zero_i;
    cnt_o  = {hi_zero_i, sel_hi | sel_lo};
  end

endmodule

// File: rtl/lead_zero_count.sv
module lead_zero_count
  import lzc_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CNT_W = lzc_levels(WIDTH)
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             all_zero_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int LEVELS = lzc_levels(WIDTH);

  genvar k;
  for (k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int NODES = WIDTH >> (k + 1);
    localparam int CW    = k + 1;
    logic [NODES-1:0]    vq;
    logic [NODES*CW-1:0] zq;

    if (k == 0) begin : g_leaf
      for (genvar n = 0; n < NODES; n++) begin : g_cell
        lzc_cell2 u_cell (
          .pair_i (word_i[2*n +: 2]),
          .zero_o (vq[n]),
          .cnt_o  (zq[n])
        );
      end
    end else begin : g_join
      for (genvar n = 0; n < NODES; n++) begin : g_node
        lzc_merge #(.HALF_CW(CW - 1), .OUT_CW(CW)) u_merge (
          .hi_zero_i (g_lvl[k-1].vq[2*n+1]),
          .lo_zero_i (g_lvl[k-1].vq[2*n]),
          .hi_cnt_i  (g_lvl[k-1].zq[(2*n+1)*(CW-1) +: (CW-1)]),
          .lo_cnt_i  (g_lvl[k-1].zq[(2*n)*(CW-1) +: (CW-1)]),
          .zero_o    (vq[n]),
          .cnt_o     (zq[n*CW +: CW])
        );
      end
    end
  end

  assign all_zero_o = g_lvl[LEVELS-1].vq[0];
  assign count_o    = g_lvl[LEVELS-1].zq[CNT_W-1:0];

endmodule

// File: rtl/lead_zero_count_chk.sv
module lead_zero_count_chk #(
  parameter int WIDTH = 64,
  parameter int CNT_W = 6
) (
  input logic [WIDTH-1:0] word_i,
  input logic             all_zero_o,
  input logic [CNT_W-1:0] count_o
);

  int top_idx;

  always_comb begin
    top_idx = WIDTH - 1 - int'(count_o);
    if (!$isunknown(word_i)) begin
      p_flag_r2: assert (all_zero_o == (word_i == '0))
        else $error("flag does not match all-zero operand");
      p_allzero_cnt_r4: assert (!all_zero_o || (&count_o))
        else $error("zero operand must give all-ones count");
      p_msb_r5: assert (!word_i[WIDTH-1] || (count_o == '0))
        else $error("top bit set must give zero count");
      p_count_r3: assert (all_zero_o || (word_i[top_idx] &&
                          ((count_o == '0) || ((word_i >> (top_idx + 1)) == '0))))
        else $error("count does not point at first set bit");
      p_lsb_r6: assert ((word_i != {{(WIDTH-1){1'b0}}, 1'b1}) ||
                        ((&count_o) && !all_zero_o))
        else $error("lone bit 0 handled wrongly");
    end
  end

endmodule

bind lead_zero_count lead_zero_count_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .word_i     (word_i),
  .all_zero_o (all_zero_o),
  .count_o    (count_o)
);

// File: tb/lead_zero_count_test.sv
module lead_zero_count_test;

  typedef struct packed {
    logic [63:0] w;
    logic [5:0]  z;
    logic        v;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_0000, 6'd63, 1'b1},
    '{64'h0000_0000_0000_0001, 6'd63, 1'b0},
    '{64'h8000_0000_0000_0000, 6'd0,  1'b0},
    '{64'h4000_0000_0000_0000, 6'd1,  1'b0},
    '{64'h0000_0001_0000_0000, 6'd31, 1'b0},
    '{64'h0000_0000_8000_0000, 6'd32, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 6'd0,  1'b0},
    '{64'h00FF_0000_0000_0000, 6'd8,  1'b0},
    '{64'h0000_0000_0000_0002, 6'd62, 1'b0},
    '{64'h0000_0000_0001_0000, 6'd47, 1'b0},
    '{64'h0001_0000_0000_0000, 6'd15, 1'b0},
    '{64'h0000_8000_0000_0000, 6'd16, 1'b0},
    '{64'h8000_0000_0000_0001, 6'd0,  1'b0},
    '{64'h0000_0000_0000_00F3, 6'd56, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [63:0]  word;
  logic         zf;
  logic [5:0]   cnt;
  logic [127:0] word_w;
  logic         zf_w;
  logic [6:0]   cnt_w;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  lead_zero_count uut (
    .word_i     (word),
    .all_zero_o (zf),
    .count_o    (cnt)
  );

  lead_zero_count #(.WIDTH(128)) uut_wide (
    .word_i     (word_w),
    .all_zero_o (zf_w),
    .count_o    (cnt_w)
  );

  function automatic int ref_lz(input logic [127:0] w, input int n);
    for (int i = n - 1; i >= 0; i--)
      if (w[i]) return n - 1 - i;
    return n - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run64(input string req, input logic [63:0] w);
    @(negedge clk);
    word = w;
    #1;
    chk({req, " count"}, int'(cnt), ref_lz({64'd0, w}, 64));
    chk({req, " flag"},  int'(zf),  int'(w == 64'd0));
  endtask

  task automatic run128(input string req, input logic [127:0] w);
    @(negedge clk);
    word_w = w;
    #1;
    chk({req, " count"}, int'(cnt_w), ref_lz(w, 128));
    chk({req, " flag"},  int'(zf_w),  int'(w == 128'd0));
  endtask

  initial begin
    word   = 64'd0;
    word_w = 128'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero operand, R2 and R4
    chk("R2 reset flag", int'(zf), 1);
    chk("R4 reset count", int'(cnt), 63);
    chk("R1 count width", $bits(cnt), 6);
    chk("R1 operand width", $bits(word), 64);

    // table walk, R3
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      word = VECS[i].w;
      #1;
      chk("R3 table count", int'(cnt), int'(VECS[i].z));
      chk("R2 table flag", int'(zf), int'(VECS[i].v));
    end

    // lone bit at every position, R3
    for (int p = 0; p < 64; p++) run64("R3 single bit", 64'd1 << p);
    // top bit set with noise below, R5
    for (int i = 0; i < 8; i++)
      run64("R5 msb set", {1'b1, 31'($urandom), 32'($urandom)});
    // only bit 0 set, R6
    @(negedge clk);
    word = 64'd1;
    #1;
    chk("R6 lsb count", int'(cnt), 63);
    chk("R6 lsb flag", int'(zf), 0);
    // return to zero, R4
    run64("R4 zero again", 64'd0);
    // random words of spread counts, R3
    for (int i = 0; i < 300; i++)
      run64("R3 random", {32'($urandom), 32'($urandom)} >> ($urandom % 65));

    // no clock needed: change operand between edges, R8
    @(posedge clk);
    #3;
    word = 64'h0000_0100_0000_0000;
    #1;
    chk("R8 no clock count", int'(cnt), 23);
    word = 64'd0;
    #1;
    chk("R8 no clock flag", int'(zf), 1);

    // 128-bit build, R7
    chk("R7 wide count width", $bits(cnt_w), 7);
    run128("R7 wide zero", 128'd0);
    for (int p = 0; p < 128; p += 5) run128("R7 wide bit", 128'd1 << p);
    for (int i = 0; i < 100; i++)
      run128("R7 wide random",
             {32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)} >> ($urandom % 129));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule